// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block sits between a synchronous host and an external asynchronous static RAM of 64K 16-bit words with separate upper and lower byte enables. The host presents one access at a time on a request port (read/write flag, word address, write data and a two-bit lane mask) and may do so only while `reqReady` is high. Reads return the word on `rspData` together with a single-cycle `rspValid` pulse; writes return nothing.

On the memory side the controller generates active-low chip select, write strobe, output enable and the two byte enables, holds the address, and drives the data bus through a separately enabled output driver. Every phase of a cycle is a whole number of clock cycles derived from nanosecond parameters by rounding up, and no phase is shorter than one cycle. Writes are ended by the write strobe rising while chip select and byte enables stay active. The data driver is switched on only after the memory has had time to release the bus following output enable, and it is switched off one cycle after the write strobe returns high. After reset no access is made until a startup delay has elapsed.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset, `reqReady` stays low and every memory strobe stays inactive (high, driver off) for exactly ceil(STARTUP_NS/CLK_NS) cycles; then `reqReady` rises.
- R2: A write stores data bits 7..0 only when mask bit 0 is 1 and bits 15..8 only when mask bit 1 is 1; a mask of 00 changes no memory contents.
- R3: A read returns memory bits for each lane whose mask bit is 1 and zero in each lane whose mask bit is 0; `rspValid` is high for exactly one cycle per read.
- R4: The write strobe is low only while chip select is low and output enable is high; output enable is low only while the write strobe is high.
- R5: During a write the write strobe stays low for max(ceil(T_PWE/CLK), ceil(T_SD/CLK), ceil(T_AW/CLK) minus the turnaround count) cycles (4 at the defaults), the data driver is on for that whole time, and the address does not change while the strobe is low.
- R6: The data driver is never on while output enable is low, turns on no earlier than ceil(T_HZOE/CLK) cycles after the request is accepted, and turns off exactly one cycle after the write strobe rises.
- R7: A read keeps output enable low for max(ceil(T_AA/CLK), ceil(T_DOE/CLK), ceil(T_RC/CLK)) cycles (5 at the defaults); the data is captured on the edge that ends that count and `rspValid` is seen in the cycle right after it.
- R8: `reqReady` is high only while no access is in progress, and a request presented while it is low is ignored.
- R9: A write keeps chip select low for at least ceil(T_WC/CLK) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 16 | Word address |
| reqWdata | input | 16 | Write data |
| reqMask | input | 2 | Lane enables, bit 0 = bits 7..0, bit 1 = bits 15..8, 1 = lane used |
| reqReady | output | 1 | Controller can accept a request |
| rspValid | output | 1 | One-cycle read data strobe |
| rspData | output | 16 | Read data, disabled lanes zero |
| memCeN | output | 1 | Chip select, active low |
| memWeN | output | 1 | Write strobe, active low |
| memOeN | output | 1 | Output enable, active low |
| memUbN | output | 1 | Upper byte enable, active low |
| memLbN | output | 1 | Lower byte enable, active low |
| memAddr | output | 16 | Memory address |
| memDqOut | output | 16 | Data to memory |
| memDqIn | input | 16 | Data from memory |
| memDqDrive | output | 1 | Enable for the data bus driver |

## Verification
The bench goes after partial-lane writes and reads, since a swapped or ignored mask bit would corrupt or leak the neighbouring byte, and after the empty mask, where a design that still pulsed a lane would overwrite stored data. Its memory model only returns valid data once the access and output-enable delays have passed, so a controller that captured a cycle early would return garbage. It watches the time between output enable rising and the driver turning on, where a missing turnaround would show as bus contention, and whether the driver is dropped one cycle after the write strobe rises. A request raised while the controller is busy must leave the memory untouched, otherwise a later read of that address shows the stray write.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  function automatic int ceilDiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // phase length in cycles, never below one
  function automatic int phaseCyc(input int ns, input int clkNs);
    return maxOf(ceilDiv(ns, clkNs), 1);
  endfunction

  typedef enum logic [2:0] {
    ST_BOOT,
    ST_IDLE,
    ST_WTURN,
    ST_WPULSE,
    ST_WHOLD,
    ST_RACC
  } ctl_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic sel;      // chip select active
    logic wrPulse;  // write strobe active
    logic rdEn;     // output enable active
    logic drive;    // data driver on
    logic load;     // latch a new request
    logic capture;  // latch read data
  } strobe_t;

endpackage

// File: rtl/sram_lane_ctl.sv
module sram_lane_ctl
  import sram_lane_pkg::*;
#(
  parameter int BOOT_CYC = 1,
  parameter int TURN_CYC = 1,
  parameter int PWE_CYC  = 1,
  parameter int HOLD_CYC = 1,
  parameter int ACC_CYC  = 1
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  output logic    reqReady,
  output strobe_t strb
);

  localparam int MAX_CYC = maxOf(maxOf(BOOT_CYC, ACC_CYC),
                                 maxOf(maxOf(TURN_CYC, PWE_CYC), HOLD_CYC));
  localparam int CNT_W = $clog2(MAX_CYC + 1);

  ctl_state_e state;
  logic [CNT_W-1:0] cnt;
  logic cntDone;

  assign cntDone = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_BOOT;
      cnt   <= CNT_W'(BOOT_CYC - 1);
    end else begin
      case (state)
        ST_BOOT: begin
          if (cntDone) state <= ST_IDLE;
          else cnt <= cnt - 1'b1;
        end
        ST_IDLE: begin
          if (reqValid) begin
            if (reqWrite) begin
              state <= ST_WTURN;
              cnt   <= CNT_W'(TURN_CYC - 1);
            end else begin
              state <= ST_RACC;
              cnt   <= CNT_W'(ACC_CYC - 1);
            end
          end
        end
        ST_WTURN: begin
          if (cntDone) begin
            state <= ST_WPULSE;
            cnt   <= CNT_W'(PWE_CYC - 1);
          end else cnt <= cnt - 1'b1;
        end
        ST_WPULSE: begin
          if (cntDone) begin
            state <= ST_WHOLD;
            cnt   <= CNT_W'(HOLD_CYC - 1);
          end else cnt <= cnt - 1'b1;
        end
        ST_WHOLD: begin
          if (cntDone) state <= ST_IDLE;
          else cnt <= cnt - 1'b1;
        end
        ST_RACC: begin
          if (cntDone) state <= ST_IDLE;
          else cnt <= cnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    reqReady     = (state == ST_IDLE);
    strb.sel     = (state == ST_WTURN) || (state == ST_WPULSE) ||
                   (state == ST_WHOLD) || (state == ST_RACC);
    strb.wrPulse = (state == ST_WPULSE);
    strb.rdEn    = (state == ST_RACC);
    strb.drive   = (state == ST_WPULSE) || (state == ST_WHOLD);
    strb.load    = (state == ST_IDLE) && reqValid;
    strb.capture = (state == ST_RACC) && cntDone;
  end

endmodule

// File: rtl/sram_lane_dp.sv
module sram_lane_dp
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  localparam int LANES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [LANES-1:0]  reqMask,
  input  logic [DATA_W-1:0] memDqIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memCeN,
  output logic              memWeN,
  output logic              memOeN,
  output logic [LANES-1:0]  laneN,
  output logic              memDqDrive,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic [LANES-1:0]  maskQ;
  logic [DATA_W-1:0] capNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
      maskQ <= '0;
    end else if (strb.load) begin
      addrQ <= reqAddr;
      dataQ <= reqWdata;
      maskQ <= reqMask;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign capNext[g*8 +: 8] = maskQ[g] ? memDqIn[g*8 +: 8] : 8'h00;
    assign laneN[g]          = ~(strb.sel & maskQ[g]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= strb.capture;
      if (strb.capture) rspData <= capNext;
    end
  end

  assign memAddr    = addrQ;
  assign memDqOut   = dataQ;
  assign memCeN     = ~strb.sel;
  assign memWeN     = ~strb.wrPulse;
  assign memOeN     = ~strb.rdEn;
  assign memDqDrive = strb.drive;

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int CLK_NS     = 10,
  parameter int STARTUP_NS = 500000,
  parameter int T_WC_NS    = 45,
  parameter int T_PWE_NS   = 35,
  parameter int T_AW_NS    = 40,
  parameter int T_SD_NS    = 25,
  parameter int T_HZOE_NS  = 15,
  parameter int T_RC_NS    = 45,
  parameter int T_AA_NS    = 45,
  parameter int T_DOE_NS   = 25
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic [15:0] reqAddr,
  input  logic [15:0] reqWdata,
  input  logic [1:0]  reqMask,
  output logic        reqReady,
  output logic        rspValid,
  output logic [15:0] rspData,
  output logic        memCeN,
  output logic        memWeN,
  output logic        memOeN,
  output logic        memUbN,
  output logic        memLbN,
  output logic [15:0] memAddr,
  output logic [15:0] memDqOut,
  input  logic [15:0] memDqIn,
  output logic        memDqDrive
);

  localparam int BOOT_CYC = phaseCyc(STARTUP_NS, CLK_NS);
  localparam int TURN_CYC = phaseCyc(T_HZOE_NS, CLK_NS);
  localparam int PWE_CYC  = maxOf(maxOf(phaseCyc(T_PWE_NS, CLK_NS),
                                        phaseCyc(T_SD_NS, CLK_NS)),
                                  ceilDiv(T_AW_NS, CLK_NS) - TURN_CYC);
  localparam int WC_CYC   = phaseCyc(T_WC_NS, CLK_NS);
  localparam int HOLD_CYC = maxOf(1, WC_CYC - TURN_CYC - PWE_CYC);
  localparam int ACC_CYC  = maxOf(maxOf(phaseCyc(T_AA_NS, CLK_NS),
                                        phaseCyc(T_DOE_NS, CLK_NS)),
                                  phaseCyc(T_RC_NS, CLK_NS));

  strobe_t strb;
  logic [1:0] laneN;

  sram_lane_ctl #(
    .BOOT_CYC(BOOT_CYC), .TURN_CYC(TURN_CYC), .PWE_CYC(PWE_CYC),
    .HOLD_CYC(HOLD_CYC), .ACC_CYC(ACC_CYC)
  ) uCtl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqReady(reqReady), .strb(strb)
  );

  sram_lane_dp #(.ADDR_W(16), .DATA_W(16)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqMask(reqMask),
    .memDqIn(memDqIn), .memAddr(memAddr), .memDqOut(memDqOut),
    .memCeN(memCeN), .memWeN(memWeN), .memOeN(memOeN), .laneN(laneN),
    .memDqDrive(memDqDrive), .rspValid(rspValid), .rspData(rspData)
  );

  assign memLbN = laneN[0];
  assign memUbN = laneN[1];

endmodule

// File: rtl/sram_lane_chk.sv
module sram_lane_chk #(
  parameter int PWE_CYC = 1,
  parameter int WC_CYC  = 1
) (
  input logic        clk,
  input logic        rstN,
  input logic        reqReady,
  input logic        rspValid,
  input logic        memCeN,
  input logic        memWeN,
  input logic        memOeN,
  input logic [15:0] memAddr,
  input logic        memDqDrive
);

  logic [15:0] weLowCnt;
  logic [15:0] ceLowCnt;
  logic        sawWrite;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      weLowCnt <= '0;
      ceLowCnt <= '0;
      sawWrite <= 1'b0;
    end else begin
      weLowCnt <= memWeN ? '0 : weLowCnt + 1'b1;
      ceLowCnt <= memCeN ? '0 : ceLowCnt + 1'b1;
      if (memCeN) sawWrite <= 1'b0;
      else if (!memWeN) sawWrite <= 1'b1;
      // R5: strobe width, checked on the cycle it returns high
      if (memWeN && weLowCnt != 0)
        assert_we_width_R5: assert (weLowCnt == 16'(PWE_CYC));
      // R9: write cycle length, checked when chip select releases
      if (memCeN && ceLowCnt != 0 && sawWrite)
        assert_write_cycle_R9: assert (ceLowCnt >= 16'(WC_CYC));
    end
  end

  assert_we_needs_sel_R4: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> (!memCeN && memOeN));

  assert_oe_excl_we_R4: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> memWeN);

  assert_addr_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |=> (memWeN || $stable(memAddr)));

  assert_drive_in_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> memDqDrive);

  assert_no_drive_oe_R6: assert property (@(posedge clk) disable iff (!rstN)
    memDqDrive |-> memOeN);

  assert_release_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |=> !memDqDrive);

  assert_rsp_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  assert_ready_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (memCeN && !memDqDrive));

endmodule

bind sram_lane_ctrl sram_lane_chk #(.PWE_CYC(PWE_CYC), .WC_CYC(WC_CYC)) uChk (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .rspValid(rspValid),
  .memCeN(memCeN), .memWeN(memWeN), .memOeN(memOeN), .memAddr(memAddr),
  .memDqDrive(memDqDrive)
);

// File: tb/sim_sram_lane_ctrl.sv
`timescale 1ns/1ps
module sim_sram_lane_ctrl;

  localparam int CLK_NS   = 10;
  localparam int BOOT_EXP = 30;  // 300 ns startup
  localparam int PWE_EXP  = 4;   // ceil(35/10)
  localparam int WC_EXP   = 5;   // ceil(45/10)
  localparam int ACC_EXP  = 5;   // ceil(45/10)

  logic clk = 0, rstN = 0;
  logic reqValid = 0, reqWrite = 0;
  logic [15:0] reqAddr = 0, reqWdata = 0;
  logic [1:0] reqMask = 0;
  logic reqReady, rspValid, memCeN, memWeN, memOeN, memUbN, memLbN, memDqDrive;
  logic [15:0] rspData, memAddr, memDqOut;
  logic [15:0] memDqIn = 16'h5A3C;

  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  sram_lane_ctrl #(.CLK_NS(CLK_NS), .STARTUP_NS(300)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqMask(reqMask),
    .reqReady(reqReady), .rspValid(rspValid), .rspData(rspData),
    .memCeN(memCeN), .memWeN(memWeN), .memOeN(memOeN), .memUbN(memUbN),
    .memLbN(memLbN), .memAddr(memAddr), .memDqOut(memDqOut),
    .memDqIn(memDqIn), .memDqDrive(memDqDrive)
  );

  // ---------------- memory model (256 words, low address byte) ----------
  logic [15:0] mem [256];
  realtime tAcc = 0, tOeFall = 0, tOeRise = -100;
  int contention = 0;

  initial for (int i = 0; i < 256; i++) mem[i] = 16'h0000;

  always @(memAddr or negedge memCeN) tAcc = $realtime;
  always @(negedge memOeN) tOeFall = $realtime;
  always @(posedge memOeN) tOeRise = $realtime;

  always @(posedge memWeN) begin
    if (!memCeN) begin
      if (!memLbN) mem[memAddr[7:0]][7:0]  = memDqDrive ? memDqOut[7:0]  : 8'hxx;
      if (!memUbN) mem[memAddr[7:0]][15:8] = memDqDrive ? memDqOut[15:8] : 8'hxx;
    end
  end

  always begin
    #1;
    if (!memCeN && !memOeN && memWeN) begin
      if (($realtime - tAcc) >= 45 && ($realtime - tOeFall) >= 25) begin
        memDqIn[7:0]  = !memLbN ? mem[memAddr[7:0]][7:0]  : 8'hA5;
        memDqIn[15:8] = !memUbN ? mem[memAddr[7:0]][15:8] : 8'hA5;
      end else memDqIn = 16'h5A3C;
      if (memDqDrive) contention++;
    end else memDqIn = 16'h5A3C;
  end

  always @(posedge memDqDrive)
    if (($realtime - tOeRise) < 15) contention++;

  // ---------------- helpers ------------------------------------------------
  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic runOp(input logic wr, input logic [15:0] a, input logic [15:0] d,
                       input logic [1:0] m, output logic [15:0] got,
                       output int weLow, output int ceLow, output int lat,
                       output bit relOk);
    bit prevWeLow, prevRose;
    while (!reqReady) begin @(posedge clk); #1; end
    @(negedge clk);
    reqValid = 1; reqWrite = wr; reqAddr = a; reqWdata = d; reqMask = m;
    @(posedge clk); #1;
    reqValid = 0;
    got = 16'hxxxx; weLow = 0; ceLow = 0; lat = -1; relOk = 1;
    prevWeLow = 0; prevRose = 0;
    for (int k = 0; k < 40; k++) begin
      if (!memWeN) weLow++;
      if (!memCeN) ceLow++;
      if (prevRose && memDqDrive) relOk = 0;
      prevRose = prevWeLow && memWeN;
      if (prevRose && !memDqDrive) relOk = 0;
      prevWeLow = !memWeN;
      if (rspValid) begin got = rspData; lat = k; end
      if (reqReady && k > 0) break;
      @(posedge clk); #1;
    end
  endtask

  typedef struct packed {
    logic        wr;
    logic [15:0] a;
    logic [15:0] d;
    logic [1:0]  m;
    logic [15:0] exp;
  } vec_t;

  // mask bit 0 = bits 7..0, bit 1 = bits 15..8
  localparam vec_t VECS [13] = '{
    '{1'b1, 16'h0010, 16'h1234, 2'b11, 16'h0000},
    '{1'b0, 16'h0010, 16'h0000, 2'b11, 16'h1234},
    '{1'b1, 16'h0010, 16'hFFEE, 2'b10, 16'h0000},
    '{1'b0, 16'h0010, 16'h0000, 2'b11, 16'hFF34},
    '{1'b1, 16'h0010, 16'h0099, 2'b01, 16'h0000},
    '{1'b0, 16'h0010, 16'h0000, 2'b11, 16'hFF99},
    '{1'b0, 16'h0010, 16'h0000, 2'b01, 16'h0099},
    '{1'b0, 16'h0010, 16'h0000, 2'b10, 16'hFF00},
    '{1'b1, 16'h0020, 16'h5555, 2'b00, 16'h0000},
    '{1'b0, 16'h0020, 16'h0000, 2'b11, 16'h0000},
    '{1'b1, 16'h1021, 16'hDEAD, 2'b11, 16'h0000},
    '{1'b0, 16'h1021, 16'h0000, 2'b11, 16'hDEAD},
    '{1'b0, 16'h0010, 16'h0000, 2'b11, 16'hFF99}
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] got;
    int weLow, ceLow, lat, n;
    bit relOk, quiet;

    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    // R1: startup hold-off
    n = 0; quiet = 1;
    @(posedge clk); #1; n++;
    while (!reqReady && n < 1000) begin
      if (!(memCeN && memWeN && memOeN && memUbN && memLbN && !memDqDrive)) quiet = 0;
      @(posedge clk); #1; n++;
    end
    check(n == BOOT_EXP, "R1", "startup cycles", n, BOOT_EXP);
    check(quiet, "R1", "strobes idle during startup", quiet, 1);

    foreach (VECS[i]) begin
      runOp(VECS[i].wr, VECS[i].a, VECS[i].d, VECS[i].m, got, weLow, ceLow, lat, relOk);
      if (VECS[i].wr) begin
        if (VECS[i].m != 2'b00) begin
          check(weLow == PWE_EXP, "R5", "write strobe cycles", weLow, PWE_EXP);
          check(ceLow >= WC_EXP, "R9", "write cycle length", ceLow, WC_EXP);
          check(relOk, "R6", "driver release after strobe", relOk, 1);
        end
      end else begin
        check(got === VECS[i].exp, (VECS[i].m == 2'b11) ? "R2" : "R3",
              "read data", got, VECS[i].exp);
        check(lat == ACC_EXP, "R7", "read capture latency", lat, ACC_EXP);
      end
    end

    // R8: request while busy is ignored
    @(negedge clk);
    reqValid = 1; reqWrite = 1; reqAddr = 16'h0030; reqWdata = 16'hAAAA; reqMask = 2'b11;
    @(posedge clk); #1;
    check(!reqReady, "R8", "ready low while busy", reqReady, 0);
    reqAddr = 16'h0040; reqWdata = 16'h7777;
    repeat (3) @(posedge clk);
    @(negedge clk); reqValid = 0;
    runOp(1'b0, 16'h0040, 16'h0, 2'b11, got, weLow, ceLow, lat, relOk);
    check(got === 16'h0000, "R8", "busy request left memory", got, 16'h0000);
    runOp(1'b0, 16'h0030, 16'h0, 2'b11, got, weLow, ceLow, lat, relOk);
    check(got === 16'hAAAA, "R2", "accepted write data", got, 16'hAAAA);

    // R3: rspValid is a single pulse
    @(posedge clk); #1;
    check(!rspValid, "R3", "rspValid single cycle", rspValid, 0);

    // R6 / R4: no contention on the bus during the whole run
    check(contention == 0, "R6", "bus contention events", contention, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule